// File: doc/BRIEF.md
# Token-Passing Ring Bus Arbiter

This block shares one system bus among a set of nodes (four by default) that sit on a logical ring. A single token moves from node to node. Only the node that holds the token may receive a grant and drive the bus; every other grant stays low. The token moves on only when the holder says it has finished, never on a timer. A node that gets the token with nothing to send gives it up after one cycle.

A copy round begins when `start` is pulsed, typically once all local work is finished and each node must move its local buffer to a common destination. The token enters at node 0, visits each node once in ascending order, and returns to node 0. A one-cycle `round_done` pulse then marks the end of the round. Between rounds the arbiter is idle and asserts no grant.

Top module: `token_ring_arbiter`

## Requirements
- R1: After a synchronous reset, `grant` is all zero, `round_done` is low, the token is at node 0, and no grant appears until `start` is pulsed.
- R2: `grant` is one-hot or all zero on every cycle.
- R3: Within one round, grants go to nodes in strictly ascending index order, beginning at node 0.
- R4: When the token reaches a node whose `req` bit is high in that cycle, that node's `grant` bit rises on the next clock edge. It stays high until the node raises its `done` bit.
- R5: When the granted node's `done` bit is sampled high, `grant` returns to zero on that edge and the token moves to the next node. That next node is evaluated in the following cycle.
- R6: A node whose `req` bit is low when the token arrives is never granted, and it passes the token on after exactly one cycle. With no requests at all, `round_done` rises on the NODES-th clock edge after the edge that samples `start`.
- R7: `round_done` is high for exactly one cycle, on the edge on which the last node releases the token. The arbiter is then idle with the token back at node 0.
- R8: `start` while a round is running, `done` from a node that does not hold a grant, and `req` from a node that does not hold the token all have no effect.
- R9: After a round completes, a new `start` begins a fresh round at node 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a copy round when idle |
| req | input | NODES | Per-node request to send, sampled when the token arrives |
| done | input | NODES | Per-node end-of-burst indication from the granted node |
| grant | output | NODES | Registered per-node bus grant |
| round_done | output | 1 | Registered one-cycle pulse at the end of a round |

## Verification
The embedded properties check on every cycle that `grant` is one-hot or zero, that a grant only ever belongs to the token position, and that nothing is granted while idle. They also check that a grant holds steady until its owner's `done` and that `round_done` never lasts two cycles. Only the bench's scenarios can show the ordering of grants across a whole round, the exact cycle on which an empty round finishes, and that mid-round `start` pulses and stray `done` bits leave the token's path unchanged. The bench shows these by comparing against a cycle-level model under directed and random traffic.

// File: rtl/trb_pkg.sv
package trb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARRIVE = 2'd1,
    ST_HOLD   = 2'd2
  } ring_state_e;
endpackage

// File: rtl/trb_ring_ptr.sv
module trb_ring_ptr #(
  parameter int NODES = 4,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load0,
  input  logic          adv,
  output logic [IW-1:0] tok,
  output logic          is_last
);
  always_ff @(posedge clk) begin
    if (rst || load0) tok <= '0;
    else if (adv)     tok <= tok + IW'(1);
  end

  assign is_last = (tok == IW'(NODES - 1));

  // R3: the token never leaves the ring
  a_r3_tok_in_range: assert property (@(posedge clk) disable iff (rst)
    (32'(tok) < NODES));
endmodule

// File: rtl/trb_round_fsm.sv
module trb_round_fsm
  import trb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req_cur,
  input  logic done_cur,
  input  logic is_last,
  output logic load0,
  output logic adv,
  output logic gnt_set,
  output logic gnt_clr,
  output logic busy,
  output logic round_done
);
  ring_state_e st_q, st_d;
  logic        pass;
  logic        rd_d;

  always_comb begin
    st_d    = st_q;
    load0   = 1'b0;
    adv     = 1'b0;
    gnt_set = 1'b0;
    gnt_clr = 1'b0;
    pass    = 1'b0;
    rd_d    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load0 = 1'b1;
          st_d  = ST_ARRIVE;
        end
      end
      ST_ARRIVE: begin
        if (req_cur) begin
          gnt_set = 1'b1;
          st_d    = ST_HOLD;
        end else begin
          pass = 1'b1;
        end
      end
      ST_HOLD: begin
        if (done_cur) begin
          gnt_clr = 1'b1;
          pass    = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (pass) begin
      if (is_last) begin
        load0 = 1'b1;
        rd_d  = 1'b1;
        st_d  = ST_IDLE;
      end else begin
        adv  = 1'b1;
        st_d = ST_ARRIVE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      round_done <= 1'b0;
    end else begin
      st_q       <= st_d;
      round_done <= rd_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R7: end-of-round pulse lasts one cycle and leaves the arbiter idle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    round_done |=> !round_done);
  a_r7_idle_after: assert property (@(posedge clk) disable iff (rst)
    round_done |-> !busy);
endmodule

// File: rtl/trb_grant_out.sv
module trb_grant_out #(
  parameter int NODES = 4,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gnt_set,
  input  logic             gnt_clr,
  input  logic [IW-1:0]    tok,
  output logic [NODES-1:0] grant
);
  for (genvar i = 0; i < NODES; i++) begin : g_node
    always_ff @(posedge clk) begin
      if (rst || gnt_clr)                    grant[i] <= 1'b0;
      else if (gnt_set && tok == IW'(i))     grant[i] <= 1'b1;
    end

    // R4: a grant only ever belongs to the token position
    a_r4_grant_holder: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> (tok == IW'(i)));
  end

  // R2: exclusive access
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter #(
  parameter int NODES = 4,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NODES-1:0] req,
  input  logic [NODES-1:0] done,
  output logic [NODES-1:0] grant,
  output logic             round_done
);
  logic [IW-1:0] tok;
  logic          is_last, load0, adv, gnt_set, gnt_clr, busy;
  logic          req_cur, done_cur;

  assign req_cur  = req[tok];
  assign done_cur = done[tok];

  trb_ring_ptr #(.NODES(NODES)) ptr_i (
    .clk(clk), .rst(rst), .load0(load0), .adv(adv),
    .tok(tok), .is_last(is_last)
  );

  trb_round_fsm fsm_i (
    .clk(clk), .rst(rst), .start(start), .req_cur(req_cur),
    .done_cur(done_cur), .is_last(is_last), .load0(load0), .adv(adv),
    .gnt_set(gnt_set), .gnt_clr(gnt_clr), .busy(busy),
    .round_done(round_done)
  );

  trb_grant_out #(.NODES(NODES)) gnt_i (
    .clk(clk), .rst(rst), .gnt_set(gnt_set), .gnt_clr(gnt_clr),
    .tok(tok), .grant(grant)
  );

  // R1: no grant outside a round
  a_r1_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (grant == '0));
  // R4: a grant holds until its owner finishes
  a_r4_grant_held: assert property (@(posedge clk) disable iff (rst)
    (|grant && !done_cur) |=> (grant == $past(grant)));
  // R5: owner's done releases the bus on the next edge
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (|grant && done_cur) |=> (grant == '0));
endmodule

// File: tb/token_ring_arbiter_tb_top.sv
`timescale 1ns/1ps
module token_ring_arbiter_tb_top;
  localparam int NODES = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NODES-1:0] req = '0;
  logic [NODES-1:0] done = '0;
  logic [NODES-1:0] grant;
  logic             round_done;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  token_ring_arbiter #(.NODES(NODES)) dut_i (
    .clk(clk), .rst(rst), .start(start), .req(req), .done(done),
    .grant(grant), .round_done(round_done)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NODES-1:0] exp_grant(input bit hold, input int tok);
    return hold ? (NODES'(1) << tok) : '0;
  endfunction

  // Cycle-level model built from the requirements
  bit m_act = 0, m_hold = 0, m_rd = 0;
  int m_tok = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_act <= 0; m_hold <= 0; m_rd <= 0; m_tok <= 0;
    end else begin
      bit pass;
      pass = 0;
      m_rd <= 0;
      if (!m_act) begin
        if (start) begin m_act <= 1; m_tok <= 0; m_hold <= 0; end
      end else if (!m_hold) begin
        if (req[m_tok]) m_hold <= 1; else pass = 1;
      end else if (done[m_tok]) begin
        m_hold <= 0; pass = 1;
      end
      if (pass) begin
        if (m_tok == NODES - 1) begin m_act <= 0; m_tok <= 0; m_rd <= 1; end
        else m_tok <= m_tok + 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  int last_g = -1;
  logic [NODES-1:0] prev_g = '0;
  always @(negedge clk) begin
    if (!rst) begin
      logic [NODES-1:0] eg;
      eg = exp_grant(m_hold, m_tok);
      chk($onehot0(grant), "R2", 32'(grant), 32'(eg));
      chk(grant == eg, cur_tag, 32'(grant), 32'(eg));
      chk(round_done == m_rd, "R7", 32'(round_done), 32'(m_rd));
      for (int i = 0; i < NODES; i++) begin
        if (grant[i] && !prev_g[i]) begin
          chk(i > last_g, "R3", i, last_g + 1);
          last_g = i;
        end
      end
      if (round_done) last_g = -1;
      prev_g = grant;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(grant == '0, "R1", 32'(grant), 0);
    chk(round_done == 1'b0, "R1", 32'(round_done), 0);
    rst = 1'b0;
    cur_tag = "R1";
    req = '1;
    done = '1;
    repeat (10) @(negedge clk);
    chk(grant == '0, "R1", 32'(grant), 0);

    // R6: empty round, timing of round_done
    cur_tag = "R6";
    req = '0; done = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= NODES + 2; k++) begin
      @(negedge clk);
      chk(round_done == (k == NODES), "R6", 32'(round_done), 32'(k == NODES));
      chk(grant == '0, "R6", 32'(grant), 0);
    end

    // R5: every node sends a one-cycle burst, done follows grant
    cur_tag = "R5";
    req = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4 * NODES; k++) begin
      done = grant;
      @(negedge clk);
    end
    done = '0;

    // R8: start mid-round and done from non-holders are ignored
    cur_tag = "R8";
    req = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      start = 1'b1;
      done = ~grant;
      @(negedge clk);
      chk(grant == 4'b0001, "R8", 32'(grant), 1);
    end
    start = 1'b0;
    for (int k = 0; k < 6 * NODES; k++) begin
      done = grant;
      @(negedge clk);
    end
    done = '0;
    repeat (3) @(negedge clk);

    // R9: a fresh round restarts at node 0
    cur_tag = "R9";
    req = 4'b1001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(grant == 4'b0001, "R9", 32'(grant), 1);
    done = 4'b0001;
    @(negedge clk);
    done = '0;
    repeat (8) @(negedge clk);
    done = grant;
    @(negedge clk);
    done = '0;
    repeat (3) @(negedge clk);

    // R4: random traffic against the model
    cur_tag = "R4";
    for (int k = 0; k < 20000; k++) begin
      req   = NODES'($urandom);
      done  = NODES'($urandom & $urandom);
      start = ($urandom % 8) == 0;
      @(negedge clk);
    end
    start = 1'b0; req = '0; done = '1;
    repeat (2 * NODES + 4) @(negedge clk);
    chk(grant == '0, "R7", 32'(grant), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule